// File: doc/BRIEF.md
# Banked Byte Memory with Pointer-Redirected Access

This block is the data-memory side of a small 8-bit processor core. The core presents an 8-bit direct address with a read strobe, a write strobe and a write byte. The block returns the byte read one cycle later. Each address falls into one of three places: a special-function window that looks the same in every bank, a general-purpose RAM window whose bank comes from a bank-select register, or an unimplemented hole. Two virtual addresses hold no storage of their own. An access to either one is re-aimed at the address held in its companion pointer register.

The two redirect ports reach different banks. Port 0 always lands in bank 0. Port 1 lands in the bank named by the bank-select register. The special-function window is shared by all banks, with one exception: the byte at 40H is present only while bank 1 is selected. When a redirected access lands on one of the virtual addresses it does nothing: a read returns 00H and a write is dropped. A handful of plain storage bytes stand in for peripheral registers, and they are brought out on ports. The number of banks (1, 2 or 4) and the start of the bank-0 RAM (60H or 80H) are parameters. Together they cover capacities of 160, 288 and 512 bytes.

Top module: `banked_dmem`

## Requirements
- R1: A synchronous active-high reset sets pointer 0, pointer 1, the bank-select register, every plain special byte, the bank-1-only byte and `rdata` to 00H. RAM contents are not cleared.
- R2: A direct access to 80H..FFH while bank select holds 0 reads and writes bank 0 RAM.
- R3: While bank select holds n with n < NUM_BANKS, a direct access to 80H..FFH reaches bank n. Each bank keeps its own storage at the same address.
- R4: With BANK0_LOW60=1, addresses 60H..7FH are RAM in bank 0 only. In any other bank they are unimplemented.
- R5: The window 00H..5FH is the same in every bank. Pointer 0 sits at 01H, pointer 1 at 03H and bank select at 04H. Plain special byte k sits at SFR_BASE+k and is output on `sfr_bytes[8k+7:8k]`.
- R6: The byte at 40H can be read or written only while bank select holds 1. At any other time a read gives 00H and a write is ignored. The byte is output on `bank1_reg`.
- R7: An access to 00H is performed at the address held in pointer 0, always in bank 0.
- R8: An access to 02H is performed at the address held in pointer 1, in the bank held by bank select.
- R9: If a redirected access lands on 00H or 02H, a read returns 00H and a write changes nothing.
- R10: Unimplemented locations read as 00H and ignore writes. These are gaps in the special window, 60H..7FH where not RAM, and banks at or above NUM_BANKS.
- R11: The data read appears on `rdata` in the cycle after the read strobe. `rdata` holds its value while no read is strobed.
- R12: When a read and a write hit the same location in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Direct address from the core |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid the cycle after `rd_en` |
| sfr_bytes | output | 8*NUM_SFR | Plain special-function bytes, byte k at [8k+7:8k] |
| bank1_reg | output | 8 | The byte at 40H that exists only in bank 1 |

## Verification
The bench runs directed sequences first. These tell bank 0 apart from bank 1 at the same address. They show that 40H appears and disappears as bank select changes. They show that port 0 ignores bank select while port 1 follows it. They show that pointer values 00H and 02H null the access. A stretch of seeded random traffic follows. It is weighted toward the pointer, bank-select and boundary addresses, so redirected writes that move pointers and banks mix with RAM and hole accesses. Every read and every special-byte output is compared with a bench-side model. Same-cycle read-and-write and idle cycles after a read separate read-first ordering and hold behaviour from a design that forwards data or drops it.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  // Fixed special-window layout that the redirect logic depends on
  localparam logic [7:0] ADDR_IND0     = 8'h00;
  localparam logic [7:0] ADDR_PTR0     = 8'h01;
  localparam logic [7:0] ADDR_IND1     = 8'h02;
  localparam logic [7:0] ADDR_PTR1     = 8'h03;
  localparam logic [7:0] ADDR_BANKSEL  = 8'h04;
  localparam logic [7:0] ADDR_BANK1REG = 8'h40;
  localparam logic [7:0] SFR_LAST      = 8'h5F;

  localparam int BANK_WORDS = 128;
  localparam int LOW_WORDS  = 32;

  // Resolved target of one access
  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] bank;
    logic       nulled;
  } dmem_tgt_t;

endpackage

// File: rtl/dmem_resolve.sv
module dmem_resolve
  import dmem_pkg::*;
(
  input  logic [7:0] addr,
  input  logic [7:0] ptr0,
  input  logic [7:0] ptr1,
  input  logic [7:0] bank_sel,
  output dmem_tgt_t  tgt
);

  logic redirected;

  always_comb begin
    tgt.addr   = addr;
    tgt.bank   = bank_sel;
    redirected = 1'b0;
    if (addr == ADDR_IND0) begin
      tgt.addr   = ptr0;
      tgt.bank   = 8'h00;
      redirected = 1'b1;
    end else if (addr == ADDR_IND1) begin
      tgt.addr   = ptr1;
      tgt.bank   = bank_sel;
      redirected = 1'b1;
    end
    // a redirect that lands on a virtual port is dropped
    tgt.nulled = redirected &&
                 ((tgt.addr == ADDR_IND0) || (tgt.addr == ADDR_IND1));
  end

endmodule

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int BANK0_LOW60 = 1,
  parameter int RAM_AW      = 9
) (
  input  dmem_tgt_t         tgt,
  output logic              ram_hit,
  output logic [RAM_AW-1:0] ram_idx,
  output logic              sfr_hit
);

  localparam logic [7:0] NB8      = 8'(NUM_BANKS);
  localparam int         LOW_BASE = NUM_BANKS * BANK_WORDS;

  logic high_hit;
  logic low_hit;

  assign high_hit = tgt.addr[7] && (tgt.bank < NB8);

  generate
    if (BANK0_LOW60 != 0) begin : g_low
      assign low_hit = (tgt.bank == 8'h00) && (tgt.addr[7:5] == 3'b011);
    end else begin : g_nolow
      assign low_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    ram_hit = !tgt.nulled && (high_hit || low_hit);
    sfr_hit = !tgt.nulled && (tgt.addr <= SFR_LAST);
    if (low_hit)
      ram_idx = RAM_AW'(LOW_BASE + int'(tgt.addr[4:0]));
    else
      ram_idx = RAM_AW'(int'(tgt.bank[1:0]) * BANK_WORDS + int'(tgt.addr[6:0]));
  end

endmodule

// File: rtl/dmem_ram.sv
module dmem_ram #(
  parameter int DEPTH = 288,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    wdata,
  output logic [7:0]    q
);

  logic [7:0] mem [DEPTH];

  // read-first single port, block-RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    if (re) q <= mem[idx];
  end

endmodule

// File: rtl/dmem_sfr_file.sv
module dmem_sfr_file
  import dmem_pkg::*;
#(
  parameter int         NUM_SFR  = 4,
  parameter logic [7:0] SFR_BASE = 8'h10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hit,
  input  dmem_tgt_t            tgt,
  input  logic                 we,
  input  logic                 re,
  input  logic [7:0]           wdata,
  output logic [7:0]           rd_q,
  output logic [7:0]           ptr0,
  output logic [7:0]           ptr1,
  output logic [7:0]           bank_sel,
  output logic [8*NUM_SFR-1:0] sfr_flat,
  output logic [7:0]           bank1_reg
);

  logic [7:0]         sfr_q [NUM_SFR];
  logic [NUM_SFR-1:0] sfr_sel;
  logic               b1_sel;
  logic [7:0]         rd_val;

  assign b1_sel = (tgt.addr == ADDR_BANK1REG) && (tgt.bank == 8'h01);

  generate
    for (genvar k = 0; k < NUM_SFR; k++) begin : g_sfr
      assign sfr_sel[k]         = (tgt.addr == 8'(int'(SFR_BASE) + k));
      assign sfr_flat[8*k +: 8] = sfr_q[k];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr0      <= '0;
      ptr1      <= '0;
      bank_sel  <= '0;
      bank1_reg <= '0;
      for (int k = 0; k < NUM_SFR; k++) sfr_q[k] <= '0;
    end else if (we && hit) begin
      if (tgt.addr == ADDR_PTR0)    ptr0     <= wdata;
      if (tgt.addr == ADDR_PTR1)    ptr1     <= wdata;
      if (tgt.addr == ADDR_BANKSEL) bank_sel <= wdata;
      if (b1_sel)                   bank1_reg <= wdata;
      for (int k = 0; k < NUM_SFR; k++)
        if (sfr_sel[k]) sfr_q[k] <= wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit) begin
      if (tgt.addr == ADDR_PTR0)    rd_val = ptr0;
      if (tgt.addr == ADDR_PTR1)    rd_val = ptr1;
      if (tgt.addr == ADDR_BANKSEL) rd_val = bank_sel;
      if (b1_sel)                   rd_val = bank1_reg;
      for (int k = 0; k < NUM_SFR; k++)
        if (sfr_sel[k]) rd_val = sfr_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_q <= '0;
    else if (re) rd_q <= rd_val;
  end

endmodule

// File: rtl/banked_dmem.sv
module banked_dmem
  import dmem_pkg::*;
#(
  parameter int         NUM_BANKS   = 2,
  parameter int         BANK0_LOW60 = 1,
  parameter int         NUM_SFR     = 4,
  parameter logic [7:0] SFR_BASE    = 8'h10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [7:0]           addr,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic [8*NUM_SFR-1:0] sfr_bytes,
  output logic [7:0]           bank1_reg
);

  localparam int RAM_DEPTH = NUM_BANKS * BANK_WORDS + ((BANK0_LOW60 != 0) ? LOW_WORDS : 0);
  localparam int RAM_AW    = $clog2(RAM_DEPTH);

  dmem_tgt_t         tgt;
  logic [7:0]        ptr0, ptr1, bank_sel;
  logic              ram_hit, sfr_hit;
  logic [RAM_AW-1:0] ram_idx;
  logic [7:0]        ram_q, sfr_rd_q;
  logic              ram_sel_q;

  dmem_resolve u_resolve (
    .addr     (addr),
    .ptr0     (ptr0),
    .ptr1     (ptr1),
    .bank_sel (bank_sel),
    .tgt      (tgt)
  );

  dmem_decode #(
    .NUM_BANKS   (NUM_BANKS),
    .BANK0_LOW60 (BANK0_LOW60),
    .RAM_AW      (RAM_AW)
  ) u_decode (
    .tgt     (tgt),
    .ram_hit (ram_hit),
    .ram_idx (ram_idx),
    .sfr_hit (sfr_hit)
  );

  dmem_ram #(
    .DEPTH (RAM_DEPTH),
    .AW    (RAM_AW)
  ) u_ram (
    .clk   (clk),
    .we    (wr_en && ram_hit),
    .re    (rd_en && ram_hit),
    .idx   (ram_idx),
    .wdata (wdata),
    .q     (ram_q)
  );

  dmem_sfr_file #(
    .NUM_SFR  (NUM_SFR),
    .SFR_BASE (SFR_BASE)
  ) u_sfr (
    .clk       (clk),
    .rst       (rst),
    .hit       (sfr_hit),
    .tgt       (tgt),
    .we        (wr_en),
    .re        (rd_en),
    .wdata     (wdata),
    .rd_q      (sfr_rd_q),
    .ptr0      (ptr0),
    .ptr1      (ptr1),
    .bank_sel  (bank_sel),
    .sfr_flat  (sfr_bytes),
    .bank1_reg (bank1_reg)
  );

  always_ff @(posedge clk) begin
    if (rst)        ram_sel_q <= 1'b0;
    else if (rd_en) ram_sel_q <= ram_hit;
  end

  assign rdata = ram_sel_q ? ram_q : sfr_rd_q;

endmodule

// File: rtl/banked_dmem_chk.sv
module banked_dmem_chk #(
  parameter int         NUM_SFR  = 4,
  parameter logic [7:0] SFR_BASE = 8'h10
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] addr,
  input logic       rd_en,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] ptr0,
  input logic [7:0] ptr1,
  input logic [7:0] bank_sel,
  input logic [7:0] bank1_reg
);

  localparam logic [7:0] GAP_ADDR = 8'(int'(SFR_BASE) + NUM_SFR);

  logic null_acc;
  logic b1_wr;
  assign null_acc = ((addr == 8'h00) && ((ptr0 == 8'h00) || (ptr0 == 8'h02))) ||
                    ((addr == 8'h02) && ((ptr1 == 8'h00) || (ptr1 == 8'h02)));
  assign b1_wr    = wr_en && (bank_sel == 8'h01) &&
                    ((addr == 8'h40) || ((addr == 8'h02) && (ptr1 == 8'h40)));

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) && !rst |-> (ptr0 == 8'h00) && (ptr1 == 8'h00) &&
                           (bank_sel == 8'h00) && (rdata == 8'h00));

  // R5
  p_banksel_write_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en && (addr == 8'h04) |=> bank_sel == $past(wdata));

  // R6
  p_bank1_guard_r6: assert property (@(posedge clk) disable iff (rst)
    !b1_wr |=> $stable(bank1_reg));

  // R9
  p_null_read_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en && null_acc |=> rdata == 8'h00);

  // R9
  p_null_write_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en && null_acc |=> $stable(ptr0) && $stable(ptr1) &&
                          $stable(bank_sel) && $stable(bank1_reg));

  // R10
  p_gap_read_r10: assert property (@(posedge clk) disable iff (rst)
    rd_en && (addr == GAP_ADDR) |=> rdata == 8'h00);

  // R11
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R12
  p_read_first_r12: assert property (@(posedge clk) disable iff (rst)
    rd_en && wr_en && (addr == 8'h04) |=> rdata == $past(bank_sel));

endmodule

bind banked_dmem banked_dmem_chk #(
  .NUM_SFR  (NUM_SFR),
  .SFR_BASE (SFR_BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .addr      (addr),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .wdata     (wdata),
  .rdata     (rdata),
  .ptr0      (ptr0),
  .ptr1      (ptr1),
  .bank_sel  (bank_sel),
  .bank1_reg (bank1_reg)
);

// File: tb/banked_dmem_test.sv
`timescale 1ns/1ps
module banked_dmem_test;

  localparam int NB   = 2;
  localparam int LOW  = 1;
  localparam int NSFR = 4;
  localparam logic [7:0] SBASE = 8'h10;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [7:0]          addr = '0;
  logic                rd_en = 1'b0;
  logic                wr_en = 1'b0;
  logic [7:0]          wdata = '0;
  logic [7:0]          rdata;
  logic [8*NSFR-1:0]   sfr_bytes;
  logic [7:0]          bank1_reg;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  banked_dmem #(.NUM_BANKS(NB), .BANK0_LOW60(LOW), .NUM_SFR(NSFR), .SFR_BASE(SBASE)) uut (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .sfr_bytes(sfr_bytes), .bank1_reg(bank1_reg)
  );

  // reference model
  logic [7:0] m_ram [0:3][0:255];
  logic [7:0] m_p0, m_p1, m_bs, m_b1;
  logic [7:0] m_sfr [0:NSFR-1];

  task automatic resolve(input logic [7:0] a, output logic [7:0] ea, output int eb,
                         output bit nul, output bit ind);
    ea = a; eb = int'(m_bs); ind = 0;
    if (a == 8'h00) begin ea = m_p0; eb = 0; ind = 1; end
    else if (a == 8'h02) begin ea = m_p1; eb = int'(m_bs); ind = 1; end
    nul = ind && (ea == 8'h00 || ea == 8'h02);
  endtask

  function automatic bit is_ram(int b, logic [7:0] a);
    if (a >= 8'h80 && b < NB) return 1;
    if (LOW != 0 && b == 0 && a >= 8'h60 && a <= 8'h7F) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] m_peek(int b, logic [7:0] a);
    if (is_ram(b, a)) return m_ram[b][a];
    if (a == 8'h01) return m_p0;
    if (a == 8'h03) return m_p1;
    if (a == 8'h04) return m_bs;
    if (a == 8'h40 && b == 1) return m_b1;
    for (int k = 0; k < NSFR; k++) if (a == 8'(int'(SBASE) + k)) return m_sfr[k];
    return 8'h00;
  endfunction

  task automatic m_poke(int b, logic [7:0] a, logic [7:0] d);
    if (is_ram(b, a)) m_ram[b][a] = d;
    else if (a == 8'h01) m_p0 = d;
    else if (a == 8'h03) m_p1 = d;
    else if (a == 8'h04) m_bs = d;
    else if (a == 8'h40 && b == 1) m_b1 = d;
    else for (int k = 0; k < NSFR; k++) if (a == 8'(int'(SBASE) + k)) m_sfr[k] = d;
  endtask

  function automatic string tag_of(int b, logic [7:0] a, bit nul, bit ind, logic [7:0] a0);
    if (nul) return "R9";
    if (ind) return (a0 == 8'h00) ? "R7" : "R8";
    if (is_ram(b, a)) begin
      if (a < 8'h80) return "R4";
      return (b == 0) ? "R2" : "R3";
    end
    if (a == 8'h40) return (b == 1) ? "R6" : "R10";
    if (a <= 8'h04) return "R5";
    for (int k = 0; k < NSFR; k++) if (a == 8'(int'(SBASE) + k)) return "R5";
    return "R10";
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    for (int k = 0; k < NSFR; k++) check8("R5", sfr_bytes[8*k +: 8], m_sfr[k]);
    check8("R6", bank1_reg, m_b1);
  endtask

  // one bus cycle; starts and ends at a falling edge
  task automatic op(logic [7:0] a, bit rd, bit wr, logic [7:0] d);
    logic [7:0] ea, exp; int eb; bit nul, ind; string tag;
    addr = a; rd_en = rd; wr_en = wr; wdata = d;
    resolve(a, ea, eb, nul, ind);
    exp = nul ? 8'h00 : m_peek(eb, ea);
    tag = tag_of(eb, ea, nul, ind, a);
    @(posedge clk);
    if (wr && !nul) m_poke(eb, ea, d);
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    if (rd) check8(tag, rdata, exp);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d); op(a, 0, 1, d); endtask
  task automatic rd(logic [7:0] a); op(a, 1, 0, 8'h00); endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  function automatic logic [7:0] pick_addr();
    case ($urandom % 10)
      0: return 8'h00;
      1: return 8'h02;
      2: return 8'h01 + 8'(($urandom % 2) * 2);
      3: return 8'h04;
      4: return 8'(int'(SBASE) + int'($urandom % (NSFR + 1)));
      5: return 8'h40;
      6: return 8'h60 + 8'($urandom % 32);
      default: return 8'h80 + 8'($urandom % 128);
    endcase
  endfunction

  function automatic logic [7:0] pick_data(logic [7:0] a);
    if (a == 8'h04) return 8'($urandom % 5);
    if (a == 8'h01 || a == 8'h03) begin
      case ($urandom % 4)
        0: return 8'($urandom % 5);
        1: return 8'h40;
        default: return 8'h60 + 8'($urandom % 160);
      endcase
    end
    return 8'($urandom);
  endfunction

  initial begin
    logic [7:0] held;
    void'($urandom(32'h5EED_0042));
    m_p0 = 0; m_p1 = 0; m_bs = 0; m_b1 = 0;
    for (int k = 0; k < NSFR; k++) m_sfr[k] = 0;
    for (int b = 0; b < 4; b++) for (int a = 0; a < 256; a++) m_ram[b][a] = 8'h00;

    // R1: reset state
    repeat (4) @(negedge clk);
    rst = 0;
    check8("R1", rdata, 8'h00);
    for (int k = 0; k < NSFR; k++) check8("R1", sfr_bytes[8*k +: 8], 8'h00);
    check8("R1", bank1_reg, 8'h00);
    rd(8'h01); rd(8'h03); rd(8'h04);

    // preload every RAM byte so no read sees an unwritten cell
    for (int b = 0; b < NB; b++) begin
      wr(8'h04, 8'(b));
      for (int a = ((b == 0 && LOW != 0) ? 8'h60 : 8'h80); a < 256; a++)
        wr(8'(a), 8'($urandom));
    end

    // R2 / R3: same address, distinct banks
    wr(8'h04, 8'h00); wr(8'h90, 8'hA5); rd(8'h90);
    wr(8'h04, 8'h01); wr(8'h90, 8'h5A); rd(8'h90);
    wr(8'h04, 8'h00); rd(8'h90);
    // R4: low RAM in bank 0, hole in bank 1
    wr(8'h70, 8'h3C); rd(8'h70);
    wr(8'h04, 8'h01); wr(8'h70, 8'hEE); rd(8'h70);
    // R5: shared special byte
    wr(SBASE + 8'h1, 8'h77); wr(8'h04, 8'h00); rd(SBASE + 8'h1); check_outputs();
    // R6: bank-1-only byte
    wr(8'h40, 8'h11); rd(8'h40); check_outputs();
    wr(8'h04, 8'h01); wr(8'h40, 8'hAB); rd(8'h40); check_outputs();
    wr(8'h04, 8'h00); rd(8'h40);
    // R7: port 0 ignores bank select
    wr(8'h01, 8'h90); wr(8'h04, 8'h01); rd(8'h00); wr(8'h00, 8'hC3); rd(8'h00);
    // R8: port 1 follows bank select
    wr(8'h03, 8'h90); rd(8'h02); wr(8'h02, 8'h29); rd(8'h02);
    wr(8'h03, 8'h40); rd(8'h02); wr(8'h02, 8'h66); check_outputs();
    // R9: redirect onto a virtual port
    wr(8'h01, 8'h02); rd(8'h00); wr(8'h00, 8'hFF); rd(8'h01);
    wr(8'h03, 8'h00); rd(8'h02); wr(8'h02, 8'hFF); rd(8'h03);
    // R10: absent bank and gap
    wr(8'h04, 8'h03); wr(8'h90, 8'h12); rd(8'h90);
    rd(SBASE + 8'(NSFR)); wr(SBASE + 8'(NSFR), 8'h34); rd(SBASE + 8'(NSFR));
    // R11: hold while idle
    wr(8'h04, 8'h00); rd(8'h90); held = rdata;
    addr = 8'h91; wdata = 8'h00;
    repeat (3) @(negedge clk);
    check8("R11", rdata, held);
    // R12: read-first on same cycle
    op(8'h95, 1, 1, 8'hD2); rd(8'h95);
    op(8'h04, 1, 1, 8'h01); rd(8'h04);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      bit r, w;
      a = pick_addr();
      r = ($urandom % 3) != 0;
      w = ($urandom % 3) == 0;
      op(a, r, w, pick_data(a));
      if ((i % 50) == 0) check_outputs();
    end
    check_outputs();
    finish_run();
  end

endmodule